// File: doc/BRIEF.md
# Single-Channel DMA Transfer Engine

This block is one DMA channel acting as a simple bus master. Software sets a 24-bit source pointer, a 24-bit destination pointer, a 24-bit unit count, a unit size and a set of mode inputs, then raises the enable. The channel moves data one unit at a time and raises a sticky interrupt once the programmed count is used up. A count of zero makes the channel run without limit.

Each unit is moved in one of two ways. In two-address form the channel reads at the source pointer and then writes the captured word at the destination pointer. In one-address form it issues a single bus cycle at the source pointer and asserts an acknowledge strobe, so a peripheral on the other side supplies or takes the data. Requests come either from the channel itself or from an active-low request pin. The pin is judged by level or by falling edge. One request moves one unit, or a whole block when block mode is used with the pin. Between units the bus is either handed back (cycle steal) or kept (burst).

All configuration inputs must stay stable while the enable is high. The request pin is taken as already synchronous to the clock.

Top module: `dma_xfer_engine`

## Requirements
- R1: After reset, cyc_o, we_o, dack_o and irq_o are 0.
- R2: With dual_i=1, each unit is a read cycle at the source pointer followed by a write cycle at the destination pointer. The write data is the read data. The address and the direction stay stable while ack_i is low.
- R3: With dual_i=0, each unit is one bus cycle at the source pointer with dack_o=1. It is a write when single_wr_i=1 and a read otherwise. dack_o is never 1 while dual_i=1.
- R4: After each unit, a pointer steps by the unit size: 1, 2 or 4 bytes for size_i 0, 1 or 2. The side's mode sets the step: 0 keeps the pointer, 1 adds the step, 2 subtracts it, and 3 keeps the pointer. The destination pointer steps only when dual_i=1.
- R5: A nonzero count_i sets how many units are moved. irq_o rises when the last unit completes. count_i=0 runs without limit and never raises irq_o.
- R6: irq_o stays 1 until irq_clr_i is pulsed.
- R7: With req_ext_i=1 and edge_i=0, a unit starts only while dreq_ni is low. While dreq_ni is held high, no bus cycle happens.
- R8: With req_ext_i=1 and edge_i=1, each falling edge of dreq_ni starts one unit. Holding dreq_ni low starts no further units.
- R9: With req_ext_i=0, the channel requests on its own and needs no dreq_ni activity.
- R10: With block_i=1 and req_ext_i=1, one request moves blk_size_i units with the bus held. With req_ext_i=0, block_i has no effect.
- R11: With burst_i=0, cyc_o drops for at least one cycle after every unit (or block). With burst_i=1 and a request still present, cyc_o stays high from one unit into the next.
- R12: Clearing en_i lets the current unit finish, and no further bus cycle starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Channel enable; the rising level loads the pointers and the count |
| src_addr_i | input | 24 | Initial source pointer |
| dst_addr_i | input | 24 | Initial destination pointer |
| count_i | input | 24 | Number of units; 0 means no limit |
| size_i | input | 2 | Unit size: 0 byte, 1 word, 2 longword |
| src_mode_i | input | 2 | Source step: 0 fixed, 1 up, 2 down, 3 fixed |
| dst_mode_i | input | 2 | Destination step, same coding as the source |
| dual_i | input | 1 | 1 two-address form, 0 one-address form |
| single_wr_i | input | 1 | Direction of the bus cycle in one-address form (1 write) |
| req_ext_i | input | 1 | 1 request from dreq_ni, 0 self request |
| edge_i | input | 1 | 1 falling-edge detection, 0 low-level detection |
| burst_i | input | 1 | 1 keep the bus between units |
| block_i | input | 1 | Block mode, honoured only with req_ext_i=1 |
| blk_size_i | input | 8 | Units per block |
| dreq_ni | input | 1 | External request, active low |
| irq_clr_i | input | 1 | Clears the interrupt flag |
| cyc_o | output | 1 | Bus cycle active |
| we_o | output | 1 | Bus cycle is a write |
| addr_o | output | 24 | Bus address |
| size_o | output | 2 | Bus unit size |
| wdata_o | output | 32 | Write data (zero in one-address form) |
| rdata_i | input | 32 | Read data |
| ack_i | input | 1 | Bus cycle completes |
| dack_o | output | 1 | Acknowledge to the peripheral in one-address form |
| irq_o | output | 1 | End-of-count interrupt flag |

## Verification
The bus hand-back between units is the hardest behaviour to see from the ports. It shows only as a one-cycle gap in cyc_o, and it must disappear in burst mode and inside a block. The bench counts rising edges of cyc_o against logged bus cycles. Each pattern has a known edge count: one per unit under cycle steal, one per block, and one per run in burst. A one-address free run is also stopped mid-stream by dropping the enable, and the bench confirms that the log stops growing. A one-cycle-per-wait-state bus model is used in the two-address test, so that addresses are held across stalled cycles.

// File: rtl/dma_pkg.sv
package dma_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_WAIT, ST_RD, ST_WR, ST_DONE
  } dma_state_e;

  localparam logic [1:0] STEP_HOLD = 2'd0;
  localparam logic [1:0] STEP_UP   = 2'd1;
  localparam logic [1:0] STEP_DOWN = 2'd2;

  function automatic logic [2:0] unit_bytes(input logic [1:0] sz);
    case (sz)
      2'd0:    return 3'd1;
      2'd1:    return 3'd2;
      default: return 3'd4;
    endcase
  endfunction
endpackage

// File: rtl/dma_req_det.sv
module dma_req_det (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic dreq_ni,
  input  logic edge_i,
  input  logic clr_i,
  input  logic take_i,
  output logic req_o
);
  logic prev_q, pend_q, fall;

  assign fall = prev_q & ~dreq_ni;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q <= 1'b1;
      pend_q <= 1'b0;
    end else begin
      prev_q <= dreq_ni;
      if (clr_i)       pend_q <= 1'b0;
      else if (fall)   pend_q <= 1'b1;
      else if (take_i) pend_q <= 1'b0;
    end
  end

  assign req_o = edge_i ? pend_q : ~dreq_ni;
endmodule

// File: rtl/dma_addr_step.sv
module dma_addr_step #(
  parameter int AW = 24
) (
  input  logic [AW-1:0] addr_i,
  input  logic [1:0]    mode_i,
  input  logic [1:0]    size_i,
  output logic [AW-1:0] next_o
);
  import dma_pkg::*;
  logic [AW-1:0] step;

  assign step = AW'(unit_bytes(size_i));

  always_comb begin
    case (mode_i)
      STEP_UP:   next_o = addr_i + step;
      STEP_DOWN: next_o = addr_i - step;
      default:   next_o = addr_i;
    endcase
  end
endmodule

// File: rtl/dma_xfer_engine.sv
module dma_xfer_engine #(
  parameter int AW = 24,
  parameter int CW = 24,
  parameter int DW = 32,
  parameter int BW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          en_i,
  input  logic [AW-1:0] src_addr_i,
  input  logic [AW-1:0] dst_addr_i,
  input  logic [CW-1:0] count_i,
  input  logic [1:0]    size_i,
  input  logic [1:0]    src_mode_i,
  input  logic [1:0]    dst_mode_i,
  input  logic          dual_i,
  input  logic          single_wr_i,
  input  logic          req_ext_i,
  input  logic          edge_i,
  input  logic          burst_i,
  input  logic          block_i,
  input  logic [BW-1:0] blk_size_i,
  input  logic          dreq_ni,
  input  logic          irq_clr_i,
  output logic          cyc_o,
  output logic          we_o,
  output logic [AW-1:0] addr_o,
  output logic [1:0]    size_o,
  output logic [DW-1:0] wdata_o,
  input  logic [DW-1:0] rdata_i,
  input  logic          ack_i,
  output logic          dack_o,
  output logic          irq_o
);
  import dma_pkg::*;
  localparam int NSIDE = 2;

  dma_state_e    st_q, st_d;
  logic [CW-1:0] cnt_q;
  logic [BW-1:0] blk_q;
  logic [DW-1:0] data_q;
  logic          free_q, irq_q;
  logic          load, unit_done, last, blk_mode, more_blk, req, burst_go, take;
  dma_state_e    first_st;

  logic [AW-1:0] ptr_q   [NSIDE];
  logic [AW-1:0] ptr_nxt [NSIDE];
  logic [AW-1:0] ptr_ini [NSIDE];
  logic [1:0]    ptr_mode[NSIDE];

  assign ptr_ini[0]  = src_addr_i;
  assign ptr_ini[1]  = dst_addr_i;
  assign ptr_mode[0] = src_mode_i;
  assign ptr_mode[1] = dst_mode_i;

  assign load      = (st_q == ST_IDLE) && en_i;
  assign unit_done = ack_i && ((st_q == ST_WR) || (st_q == ST_RD && !dual_i));
  assign last      = !free_q && (cnt_q == CW'(1));
  assign blk_mode  = block_i && req_ext_i;
  assign more_blk  = blk_mode && (blk_q != '0);
  assign burst_go  = burst_i && !blk_mode && req;
  assign first_st  = (dual_i || !single_wr_i) ? ST_RD : ST_WR;

  // request consumed when a unit (or block) starts from a request
  assign take = ((st_q == ST_WAIT) && en_i && req) ||
                (unit_done && !last && en_i && !more_blk && burst_go);

  dma_req_det u_req (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .dreq_ni(dreq_ni),
    .edge_i (edge_i),
    .clr_i  (st_q == ST_IDLE),
    .take_i (take),
    .req_o  (req_det)
  );
  logic req_det;
  assign req = req_ext_i ? req_det : 1'b1;

  for (genvar gi = 0; gi < NSIDE; gi++) begin : g_side
    dma_addr_step #(.AW(AW)) u_step (
      .addr_i(ptr_q[gi]),
      .mode_i(ptr_mode[gi]),
      .size_i(size_i),
      .next_o(ptr_nxt[gi])
    );
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                            ptr_q[gi] <= '0;
      else if (load)                          ptr_q[gi] <= ptr_ini[gi];
      else if (unit_done && (gi == 0 || dual_i)) ptr_q[gi] <= ptr_nxt[gi];
    end
  end

  always_comb begin
    st_d = st_q;
    case (st_q)
      ST_IDLE: if (en_i) st_d = ST_WAIT;
      ST_WAIT: begin
        if (!en_i)    st_d = ST_IDLE;
        else if (req) st_d = first_st;
      end
      ST_RD, ST_WR: begin
        if (st_q == ST_RD && ack_i && dual_i) st_d = ST_WR;
        else if (unit_done) begin
          if (last)                     st_d = ST_DONE;
          else if (!en_i)               st_d = ST_IDLE;
          else if (more_blk || burst_go) st_d = first_st;
          else                          st_d = ST_WAIT;
        end
      end
      ST_DONE: if (!en_i) st_d = ST_IDLE;
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      cnt_q  <= '0;
      free_q <= 1'b0;
      blk_q  <= '0;
      data_q <= '0;
      irq_q  <= 1'b0;
    end else begin
      st_q <= st_d;
      if (load) begin
        cnt_q  <= count_i;
        free_q <= (count_i == '0);
      end else if (unit_done && !free_q) begin
        cnt_q <= cnt_q - CW'(1);
      end
      if (st_q == ST_WAIT && st_d != ST_WAIT && st_d != ST_IDLE)
        blk_q <= blk_size_i - BW'(1);
      else if (unit_done && more_blk)
        blk_q <= blk_q - BW'(1);
      if (st_q == ST_RD && ack_i && dual_i) data_q <= rdata_i;
      if (unit_done && last) irq_q <= 1'b1;
      else if (irq_clr_i)    irq_q <= 1'b0;
    end
  end

  assign cyc_o   = (st_q == ST_RD) || (st_q == ST_WR);
  assign we_o    = (st_q == ST_WR);
  assign addr_o  = (st_q == ST_WR && dual_i) ? ptr_q[1] : ptr_q[0];
  assign size_o  = size_i;
  assign wdata_o = dual_i ? data_q : '0;
  assign dack_o  = cyc_o && !dual_i;
  assign irq_o   = irq_q;
endmodule

// File: rtl/dma_xfer_engine_chk.sv
module dma_xfer_engine_chk #(
  parameter int AW = 24
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          en_i,
  input logic          dual_i,
  input logic          req_ext_i,
  input logic          burst_i,
  input logic          block_i,
  input logic          irq_clr_i,
  input logic          cyc_o,
  input logic          we_o,
  input logic [AW-1:0] addr_o,
  input logic          ack_i,
  input logic          dack_o,
  input logic          irq_o
);
  a_r2_wr_after_rd: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cyc_o && !we_o && ack_i && dual_i) |=> (cyc_o && we_o));

  a_r2_addr_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cyc_o && !ack_i) |=> (cyc_o && $stable(addr_o) && $stable(we_o)));

  a_r3_no_dack_dual: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dual_i |-> !dack_o);

  a_r6_irq_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_o && !irq_clr_i) |=> irq_o);

  a_r11_steal_release: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cyc_o && ack_i && (we_o || !dual_i) && !burst_i && !(block_i && req_ext_i))
    |=> !cyc_o);

  a_r12_stay_stopped: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en_i && !cyc_o) |=> !cyc_o);
endmodule

bind dma_xfer_engine dma_xfer_engine_chk #(.AW(AW)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .en_i     (en_i),
  .dual_i   (dual_i),
  .req_ext_i(req_ext_i),
  .burst_i  (burst_i),
  .block_i  (block_i),
  .irq_clr_i(irq_clr_i),
  .cyc_o    (cyc_o),
  .we_o     (we_o),
  .addr_o   (addr_o),
  .ack_i    (ack_i),
  .dack_o   (dack_o),
  .irq_o    (irq_o)
);

// File: tb/tb_dma_xfer_engine.sv
module tb_dma_xfer_engine;
  logic clk = 1'b0, rst_ni = 1'b0;
  logic en = 0, dual = 0, single_wr = 0, req_ext = 0, edge_m = 0;
  logic burst = 0, block = 0, dreq_n = 1, irq_clr = 0, slow = 0, ws = 0;
  logic [23:0] src = 0, dst = 0, count = 0;
  logic [1:0]  size = 0, smode = 0, dmode = 0;
  logic [7:0]  blk = 0;
  logic        cyc_o, we_o, dack_o, irq_o, ack_i;
  logic [23:0] addr_o;
  logic [1:0]  size_o;
  logic [31:0] wdata_o, rdata_i;

  always #5 clk = ~clk;

  dma_xfer_engine dut (
    .clk_i(clk), .rst_ni(rst_ni), .en_i(en), .src_addr_i(src), .dst_addr_i(dst),
    .count_i(count), .size_i(size), .src_mode_i(smode), .dst_mode_i(dmode),
    .dual_i(dual), .single_wr_i(single_wr), .req_ext_i(req_ext), .edge_i(edge_m),
    .burst_i(burst), .block_i(block), .blk_size_i(blk), .dreq_ni(dreq_n),
    .irq_clr_i(irq_clr), .cyc_o(cyc_o), .we_o(we_o), .addr_o(addr_o),
    .size_o(size_o), .wdata_o(wdata_o), .rdata_i(rdata_i), .ack_i(ack_i),
    .dack_o(dack_o), .irq_o(irq_o)
  );

  // bus model: optional one wait state per cycle
  assign ack_i   = cyc_o && (!slow || ws);
  assign rdata_i = {8'hA5, addr_o};
  always @(posedge clk) ws <= cyc_o && !ack_i;

  // bus cycle log
  logic        lg_we   [512];
  logic        lg_dack [512];
  logic [23:0] lg_addr [512];
  logic [31:0] lg_wd   [512];
  int n_log = 0, n_rise = 0;
  logic prev_cyc = 0;
  always @(posedge clk) begin
    if (cyc_o && ack_i) begin
      if (n_log < 512) begin
        lg_we[n_log]   <= we_o;
        lg_dack[n_log] <= dack_o;
        lg_addr[n_log] <= addr_o;
        lg_wd[n_log]   <= wdata_o;
      end
      n_log <= n_log + 1;
    end
    if (cyc_o && !prev_cyc) n_rise <= n_rise + 1;
    prev_cyc <= cyc_o;
  end

  int n_chk = 0, n_fail = 0;
  bit fin = 0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic cfg_clear();
    @(negedge clk);
    en = 0; dual = 0; single_wr = 0; req_ext = 0; edge_m = 0; burst = 0;
    block = 0; dreq_n = 1; slow = 0; size = 0; smode = 0; dmode = 0;
    blk = 0; count = 0; src = 0; dst = 0;
  endtask

  task automatic stop_and_clear();
    @(negedge clk); en = 0; irq_clr = 1;
    @(negedge clk); irq_clr = 0;
    @(negedge clk);
  endtask

  task automatic wait_irq(input int lim);
    for (int k = 0; k < lim && !irq_o; k++) @(negedge clk);
  endtask

  task automatic t_reset();
    chk("R1 cyc", 32'(cyc_o), 0);
    chk("R1 irq", 32'(irq_o), 0);
    chk("R1 dack", 32'(dack_o), 0);
    chk("R1 we", 32'(we_o), 0);
  endtask

  task automatic t_dual_steal();
    int b, r;
    cfg_clear();
    dual = 1; size = 1; smode = 1; dmode = 2; src = 24'h001000; dst = 24'h002000;
    count = 3; slow = 1;
    b = n_log; r = n_rise;
    @(negedge clk); en = 1;
    wait_irq(100);
    chk("R5 irq after 3 units", 32'(irq_o), 1);
    chk("R2 cycle count", n_log - b, 6);
    chk("R11 steal rises", n_rise - r, 3);
    for (int i = 0; i < 3; i++) begin
      chk("R2 rd dir", 32'(lg_we[b+2*i]), 0);
      chk("R4 src step word up", 32'(lg_addr[b+2*i]), 32'(24'h001000 + 2*i));
      chk("R2 wr dir", 32'(lg_we[b+2*i+1]), 1);
      chk("R4 dst step word down", 32'(lg_addr[b+2*i+1]), 32'(24'h002000 - 2*i));
      chk("R2 wr data", lg_wd[b+2*i+1], {8'hA5, 24'h001000 + 24'(2*i)});
    end
    // R6: flag holds until cleared
    repeat (5) @(negedge clk);
    chk("R6 irq held", 32'(irq_o), 1);
    irq_clr = 1; @(negedge clk); irq_clr = 0;
    chk("R6 irq cleared", 32'(irq_o), 0);
    stop_and_clear();
  endtask

  task automatic t_single_wr();
    int b;
    cfg_clear();
    single_wr = 1; size = 2; smode = 2; dmode = 1; src = 24'h005000; dst = 24'h00F000;
    count = 2;
    b = n_log;
    @(negedge clk); en = 1;
    wait_irq(50);
    chk("R3 unit count", n_log - b, 2);
    chk("R5 irq", 32'(irq_o), 1);
    for (int i = 0; i < 2; i++) begin
      chk("R3 write dir", 32'(lg_we[b+i]), 1);
      chk("R3 dack", 32'(lg_dack[b+i]), 1);
      chk("R4 long step down", 32'(lg_addr[b+i]), 32'(24'h005000 - 4*i));
    end
    stop_and_clear();
  endtask

  task automatic t_level();
    int b;
    cfg_clear();
    req_ext = 1; size = 0; smode = 1; src = 24'h000100; count = 4;
    b = n_log;
    @(negedge clk); en = 1;
    repeat (10) @(negedge clk);
    chk("R7 no cycles while high", n_log - b, 0);
    dreq_n = 0; @(negedge clk); dreq_n = 1;
    repeat (6) @(negedge clk);
    chk("R7 one-cycle low gives one unit", n_log - b, 1);
    chk("R3 read dir", 32'(lg_we[b]), 0);
    chk("R3 dack read", 32'(lg_dack[b]), 1);
    stop_and_clear();
  endtask

  task automatic t_edge();
    int b;
    cfg_clear();
    req_ext = 1; edge_m = 1; size = 0; smode = 1; src = 24'h000200; count = 2;
    b = n_log;
    @(negedge clk); en = 1;
    @(negedge clk); dreq_n = 0;
    repeat (20) @(negedge clk);
    chk("R8 held low gives one unit", n_log - b, 1);
    chk("R5 no irq yet", 32'(irq_o), 0);
    dreq_n = 1; repeat (2) @(negedge clk);
    dreq_n = 0; repeat (8) @(negedge clk);
    chk("R8 second edge", n_log - b, 2);
    chk("R4 byte step up", 32'(lg_addr[b+1]), 32'h000201);
    chk("R5 irq after count", 32'(irq_o), 1);
    stop_and_clear();
  endtask

  task automatic t_block();
    int b, r;
    cfg_clear();
    req_ext = 1; edge_m = 1; block = 1; blk = 3; size = 0; smode = 1;
    src = 24'h000300; count = 6;
    b = n_log; r = n_rise;
    @(negedge clk); en = 1;
    @(negedge clk); dreq_n = 0;
    repeat (12) @(negedge clk);
    chk("R10 one edge gives a block", n_log - b, 3);
    chk("R10 bus held for block", n_rise - r, 1);
    chk("R10 block addr", 32'(lg_addr[b+2]), 32'h000302);
    dreq_n = 1; repeat (2) @(negedge clk);
    dreq_n = 0; repeat (12) @(negedge clk);
    chk("R10 second block", n_log - b, 6);
    chk("R5 irq after blocks", 32'(irq_o), 1);
    stop_and_clear();
  endtask

  task automatic t_block_auto();
    int b, r;
    cfg_clear();
    block = 1; blk = 4; size = 0; src = 24'h000400; count = 2;
    b = n_log; r = n_rise;
    @(negedge clk); en = 1;
    wait_irq(40);
    chk("R10 block ignored: units", n_log - b, 2);
    chk("R10 block ignored: bus released", n_rise - r, 2);
    chk("R9 auto request done", 32'(irq_o), 1);
    stop_and_clear();
  endtask

  task automatic t_burst();
    int b, r;
    cfg_clear();
    dual = 1; burst = 1; size = 2; smode = 1; dmode = 0;
    src = 24'h003000; dst = 24'h004000; count = 3;
    b = n_log; r = n_rise;
    @(negedge clk); en = 1;
    wait_irq(40);
    chk("R11 burst cycles", n_log - b, 6);
    chk("R11 burst single rise", n_rise - r, 1);
    chk("R4 src long up", 32'(lg_addr[b+4]), 32'h003008);
    chk("R4 dst fixed", 32'(lg_addr[b+5]), 32'h004000);
    stop_and_clear();
  endtask

  task automatic t_free_stop();
    int b, n1;
    cfg_clear();
    single_wr = 1; size = 1; smode = 3; src = 24'h000600; count = 0;
    b = n_log;
    @(negedge clk); en = 1;
    repeat (30) @(negedge clk);
    chk("R5 free run moves many", 32'(n_log - b > 10), 1);
    chk("R5 free run no irq", 32'(irq_o), 0);
    chk("R4 mode 3 fixed", 32'(lg_addr[b+5]), 32'h000600);
    en = 0;
    repeat (3) @(negedge clk);
    n1 = n_log;
    repeat (20) @(negedge clk);
    chk("R12 stopped", n_log - n1, 0);
    chk("R12 no cyc", 32'(cyc_o), 0);
    stop_and_clear();
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!fin) begin
      fin = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      summary();
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1;
    @(negedge clk);
    t_reset();
    t_dual_steal();
    t_single_wr();
    t_level();
    t_edge();
    t_block();
    t_block_auto();
    t_burst();
    t_free_stop();
    if (!fin) begin
      fin = 1;
      summary();
      $finish;
    end
  end
endmodule